// File: doc/BRIEF.md
# Serial Receiver Error Status Unit

This block gathers the error conditions of a frame-based serial receiver and keeps them as four sticky status bits: CRC error, alignment error, receive abort and FIFO overrun. It owns the receiver enable bit and the receive-done flag. Any recorded error raises the receive-error interrupt and drops the enable. An error also keeps the done flag from being set. The flags are read-only. The only way to clear them is for software to set the enable again.

Two line disciplines are supported, selected by `mode_csma` (0 = SDLC-style flagged framing, 1 = CSMA/CD). In SDLC mode the end-of-frame checks are independent. In CSMA/CD mode an alignment fault is only reported together with a CRC failure, and the CRC and alignment bits never appear together. The CRC engine, bit counter and FIFO sit outside the block. The bit counter supplies `bit_count`, the number of bits between the opening and closing flags. It does not count the up to 7 trailing dribble bits that may follow the closing flag, so those bits can never cause an error.

The control is a four-state machine. `OFF` is the state after reset: enable low, no done. `ARMED` means enabled and receiving. `DONE` means enabled and the last frame ended cleanly. `FAULT` means an error was recorded and the enable is low. The transitions are as follows. `sw_set_enable` moves any state to `ARMED`; this is the set transition. `ARMED` goes to `FAULT` on any error event; this is the error transition. `ARMED` goes to `DONE` on a clean end of frame; this is the clean-end transition. `DONE` goes to `FAULT` on any error event. `OFF` and `FAULT` stay where they are until the set transition.

Top module: `rx_err_status`

## Requirements
- R1: After reset all four flags, `err_irq`, `rx_enable` and `rx_done` are 0.
- R2: A cycle with `sw_set_enable` high leaves, one cycle later, `rx_enable`=1, all flags 0, `err_irq`=0 and `rx_done`=0. Any error event in that same cycle is discarded.
- R3: In SDLC mode (`mode_csma`=0), at `eof_pulse` the CRC flag is set exactly when `crc_ok`=0. The alignment flag is set exactly when `bit_count` modulo 8 is not 0. The two are independent.
- R4: In CSMA/CD mode (`mode_csma`=1), at `eof_pulse` with `crc_ok`=1 no flag is set. With `crc_ok`=0 and `bit_count` a multiple of 8, only the CRC flag is set. With `crc_ok`=0 and `bit_count` not a multiple of 8, only the alignment flag is set.
- R5: The abort flag is set by `line_idle` in SDLC mode and by `collision` in CSMA/CD mode, and only while `data_in_fifo`=1. The other mode's cause, or the cause without `data_in_fifo`, has no effect.
- R6: The overrun flag is set when `push_req` and `fifo_full` are both high.
- R7: The flags are sticky until R2. `err_irq` is high exactly when a flag is high. `rx_enable` drops on the same edge that sets a flag.
- R8: A clean `eof_pulse` while enabled gives `rx_done`=1 one cycle later. An `eof_pulse` that comes with any error event gives `rx_done`=0 and enters `FAULT`.
- R9: While `rx_enable`=0, error events and `eof_pulse` change no flag and no output.
- R10: An error event after `rx_done` is set clears `rx_done` and enters `FAULT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_csma | input | 1 | 0 = SDLC, 1 = CSMA/CD |
| eof_pulse | input | 1 | End-of-frame flag seen |
| crc_ok | input | 1 | CRC check result, valid with eof_pulse |
| bit_count | input | CNT_W | Bits between opening and closing flags, dribble excluded |
| line_idle | input | 1 | Line-idle detected |
| collision | input | 1 | Collision detected |
| data_in_fifo | input | 1 | Current frame has already pushed data |
| push_req | input | 1 | Received byte ready to push |
| fifo_full | input | 1 | Receive FIFO full |
| sw_set_enable | input | 1 | Software write setting the enable bit |
| flag_crc | output | 1 | Sticky CRC error |
| flag_align | output | 1 | Sticky alignment error |
| flag_abort | output | 1 | Sticky receive abort |
| flag_ovr | output | 1 | Sticky FIFO overrun |
| err_irq | output | 1 | Receive-error interrupt |
| rx_enable | output | 1 | Receiver enable bit |
| rx_done | output | 1 | Receive-done flag |

## Verification
Every result of this block is registered once. A stimulus sampled at one rising edge shows up at the outputs immediately after that edge. This holds for flag set and clear, the enable change, the interrupt and the done flag. The bench drives each stimulus on a falling edge and holds it for exactly one rising edge. It clears the stimulus at the next falling edge and compares all seven outputs there, half a cycle after they settle. Checks of stickiness and of ignored inputs repeat the comparison after further idle cycles, so a late or spurious change is also caught.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    typedef struct packed {
        logic crc;
        logic align;
        logic abort;
        logic ovr;
    } rxerr_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } rxst_t;
endpackage

// File: rtl/rx_err_detect.sv
module rx_err_detect
    import rx_err_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BYTE_BITS = 8
) (
    input  logic             mode_csma,
    input  logic             eof_pulse,
    input  logic             crc_ok,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             line_idle,
    input  logic             collision,
    input  logic             data_in_fifo,
    input  logic             push_req,
    input  logic             fifo_full,
    output rxerr_t           set_ev
);
    localparam logic [CNT_W-1:0] BYTE_W = CNT_W'(BYTE_BITS);

    logic misaligned;
    logic abort_cause;

    always_comb begin
        misaligned  = (bit_count % BYTE_W) != '0;
        abort_cause = mode_csma ? collision : line_idle;
        set_ev      = '0;
        if (eof_pulse) begin
            if (mode_csma) begin
                // CSMA/CD: alignment only reported under a CRC failure
                set_ev.crc   = !crc_ok && !misaligned;
                set_ev.align = !crc_ok &&  misaligned;
            end else begin
                set_ev.crc   = !crc_ok;
                set_ev.align = misaligned;
            end
        end
        set_ev.abort = data_in_fifo && abort_cause;
        set_ev.ovr   = push_req && fifo_full;
    end
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags
    import rx_err_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   capture,
    input  rxerr_t set_ev,
    output rxerr_t flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (clear) begin
            flags <= '0;
        end else if (capture) begin
            flags <= flags | set_ev;
        end
    end
endmodule

// File: rtl/rx_err_fsm.sv
module rx_err_fsm
    import rx_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic any_err,
    input  logic eof,
    output logic enable,
    output logic done
);
    rxst_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (sw_set) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_OFF;
                ST_ARMED: begin
                    if (any_err)  state_nx = ST_FAULT;
                    else if (eof) state_nx = ST_DONE;
                end
                ST_DONE:  begin
                    if (any_err)  state_nx = ST_FAULT;
                end
                ST_FAULT: state_nx = ST_FAULT;
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        enable = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_ARMED: enable = 1'b1;
            ST_DONE:  begin
                enable = 1'b1;
                done   = 1'b1;
            end
            ST_FAULT: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_err_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BYTE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_csma,
    input  logic             eof_pulse,
    input  logic             crc_ok,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             line_idle,
    input  logic             collision,
    input  logic             data_in_fifo,
    input  logic             push_req,
    input  logic             fifo_full,
    input  logic             sw_set_enable,
    output logic             flag_crc,
    output logic             flag_align,
    output logic             flag_abort,
    output logic             flag_ovr,
    output logic             err_irq,
    output logic             rx_enable,
    output logic             rx_done
);
    rxerr_t set_ev;
    rxerr_t flags;
    logic   any_err;

    rx_err_detect #(.CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_detect (
        .mode_csma   (mode_csma),
        .eof_pulse   (eof_pulse),
        .crc_ok      (crc_ok),
        .bit_count   (bit_count),
        .line_idle   (line_idle),
        .collision   (collision),
        .data_in_fifo(data_in_fifo),
        .push_req    (push_req),
        .fifo_full   (fifo_full),
        .set_ev      (set_ev)
    );

    // Events only count while the receiver is enabled
    assign any_err = rx_enable && (set_ev != '0);

    rx_err_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sw_set_enable),
        .capture(rx_enable),
        .set_ev (set_ev),
        .flags  (flags)
    );

    rx_err_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (sw_set_enable),
        .any_err(any_err),
        .eof    (eof_pulse),
        .enable (rx_enable),
        .done   (rx_done)
    );

    assign flag_crc   = flags.crc;
    assign flag_align = flags.align;
    assign flag_abort = flags.abort;
    assign flag_ovr   = flags.ovr;
    assign err_irq    = flags != '0;
endmodule

// File: rtl/rx_err_status_chk.sv
module rx_err_status_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_csma,
    input logic eof_pulse,
    input logic push_req,
    input logic fifo_full,
    input logic sw_set_enable,
    input logic flag_crc,
    input logic flag_align,
    input logic flag_ovr,
    input logic err_irq,
    input logic rx_enable,
    input logic rx_done
);
    assert_set_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_enable |=> (rx_enable && !err_irq && !rx_done));

    assert_csma_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && eof_pulse && mode_csma && !sw_set_enable) |=> !(flag_crc && flag_align));

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && push_req && fifo_full && !sw_set_enable) |=> flag_ovr);

    assert_irq_kills_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> !rx_enable);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr && !sw_set_enable) |=> flag_ovr);

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !err_irq);
endmodule

bind rx_err_status rx_err_status_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_csma    (mode_csma),
    .eof_pulse    (eof_pulse),
    .push_req     (push_req),
    .fifo_full    (fifo_full),
    .sw_set_enable(sw_set_enable),
    .flag_crc     (flag_crc),
    .flag_align   (flag_align),
    .flag_ovr     (flag_ovr),
    .err_irq      (err_irq),
    .rx_enable    (rx_enable),
    .rx_done      (rx_done)
);

// File: tb/test_rx_err_status.sv
module test_rx_err_status;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_csma = 1'b0, eof_pulse = 1'b0, crc_ok = 1'b1;
    logic [CNT_W-1:0] bit_count = '0;
    logic line_idle = 1'b0, collision = 1'b0, data_in_fifo = 1'b0;
    logic push_req = 1'b0, fifo_full = 1'b0, sw_set_enable = 1'b0;
    logic flag_crc, flag_align, flag_abort, flag_ovr, err_irq, rx_enable, rx_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_err_status #(.CNT_W(CNT_W)) i_rx_err_status (.*);

    // Output vector: {crc, align, abort, ovr, irq, enable, done}
    localparam logic [6:0] V_IDLE  = 7'b0000_000;
    localparam logic [6:0] V_ARMED = 7'b0000_010;
    localparam logic [6:0] V_DONE  = 7'b0000_011;
    localparam logic [6:0] V_CRC   = 7'b1000_100;
    localparam logic [6:0] V_ALIGN = 7'b0100_100;
    localparam logic [6:0] V_BOTH  = 7'b1100_100;
    localparam logic [6:0] V_ABORT = 7'b0010_100;
    localparam logic [6:0] V_OVR   = 7'b0001_100;

    task automatic expect_out(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {flag_crc, flag_align, flag_abort, flag_ovr, err_irq, rx_enable, rx_done};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        eof_pulse = 0; crc_ok = 1; bit_count = '0; line_idle = 0; collision = 0;
        data_in_fifo = 0; push_req = 0; fifo_full = 0; sw_set_enable = 0;
    endtask

    // Hold current stimulus for one rising edge, then clear it
    task automatic one_edge();
        @(negedge clk);
        clear_in();
    endtask

    task automatic arm();
        @(negedge clk);
        sw_set_enable = 1;
        one_edge();
    endtask

    task automatic send_eof(input logic ok, input int bits);
        @(negedge clk);
        eof_pulse = 1; crc_ok = ok; bit_count = CNT_W'(bits);
        one_edge();
    endtask

    task automatic t_reset();
        expect_out("R1 reset", V_IDLE);
    endtask

    task automatic t_arm();
        arm();
        expect_out("R2 arm", V_ARMED);
    endtask

    task automatic t_sdlc_eof();
        mode_csma = 0;
        arm(); send_eof(1, 64); expect_out("R3 sdlc clean 64", V_DONE);
        arm(); send_eof(0, 64); expect_out("R3 sdlc crc only", V_CRC);
        arm(); send_eof(1, 61); expect_out("R3 sdlc align only", V_ALIGN);
        arm(); send_eof(0, 13); expect_out("R3 sdlc both", V_BOTH);
        arm(); send_eof(1, 71); expect_out("R3 sdlc 71 misaligned", V_ALIGN);
        arm(); send_eof(1, 72); expect_out("R3 sdlc 72 aligned", V_DONE);
    endtask

    task automatic t_csma_eof();
        mode_csma = 1;
        arm(); send_eof(1, 13); expect_out("R4 csma crc ok misaligned", V_DONE);
        arm(); send_eof(0, 16); expect_out("R4 csma crc only", V_CRC);
        arm(); send_eof(0, 13); expect_out("R4 csma align only", V_ALIGN);
        mode_csma = 0;
    endtask

    task automatic t_abort();
        mode_csma = 0;
        arm(); @(negedge clk); line_idle = 1; data_in_fifo = 1; one_edge();
        expect_out("R5 sdlc idle abort", V_ABORT);
        arm(); @(negedge clk); line_idle = 1; one_edge();
        expect_out("R5 sdlc idle no data", V_ARMED);
        @(negedge clk); collision = 1; data_in_fifo = 1; one_edge();
        expect_out("R5 sdlc collision ignored", V_ARMED);
        mode_csma = 1;
        @(negedge clk); line_idle = 1; data_in_fifo = 1; one_edge();
        expect_out("R5 csma idle ignored", V_ARMED);
        @(negedge clk); collision = 1; data_in_fifo = 1; one_edge();
        expect_out("R5 csma collision abort", V_ABORT);
        mode_csma = 0;
    endtask

    task automatic t_overrun();
        arm(); @(negedge clk); push_req = 1; one_edge();
        expect_out("R6 push not full", V_ARMED);
        @(negedge clk); fifo_full = 1; one_edge();
        expect_out("R6 full no push", V_ARMED);
        @(negedge clk); push_req = 1; fifo_full = 1; one_edge();
        expect_out("R6 overrun", V_OVR);
    endtask

    task automatic t_sticky();
        repeat (3) @(negedge clk);
        expect_out("R7 sticky", V_OVR);
        arm();
        expect_out("R7 cleared by enable", V_ARMED);
    endtask

    task automatic t_ignored();
        arm(); @(negedge clk); push_req = 1; fifo_full = 1; one_edge();
        @(negedge clk); eof_pulse = 1; crc_ok = 0; bit_count = 5; one_edge();
        expect_out("R9 ignored in fault", V_OVR);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        @(negedge clk); eof_pulse = 1; crc_ok = 0; bit_count = 3;
        push_req = 1; fifo_full = 1; one_edge();
        expect_out("R9 ignored when off", V_IDLE);
    endtask

    task automatic t_priority();
        @(negedge clk); sw_set_enable = 1; push_req = 1; fifo_full = 1;
        eof_pulse = 1; crc_ok = 0; one_edge();
        expect_out("R2 set wins over events", V_ARMED);
    endtask

    task automatic t_done_paths();
        arm(); @(negedge clk); eof_pulse = 1; bit_count = 8; push_req = 1; fifo_full = 1; one_edge();
        expect_out("R8 eof with overrun gives no done", V_OVR);
        arm(); send_eof(1, 40); expect_out("R8 clean done", V_DONE);
        @(negedge clk); push_req = 1; fifo_full = 1; one_edge();
        expect_out("R10 error after done", V_OVR);
    endtask

    initial begin
        clear_in();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_sdlc_eof();
        t_csma_eof();
        t_abort();
        t_overrun();
        t_sticky();
        t_ignored();
        t_priority();
        t_done_paths();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule